// File: doc/BRIEF.md
# Cross-Chunk Prefix Combiner with Coverage-Flag Jumping

This block turns a set of per-chunk totals into running offsets across eight chunks without any global barrier. It holds a shared table with one entry per chunk. Each entry is a pair: a coverage count and a partial sum. One agent per chunk posts the chunk's own total when that total becomes available. The agent then repeatedly looks back by its own coverage count and folds the entry it finds there into its own entry. Once the entry it reaches reaches back to chunk 1, the agent knows the full prefix. It then reports the sum of all earlier chunks as that chunk's offset.

All agents share the table through a round-robin arbiter. The granted agent reads its target pair and writes its own pair in the same cycle, so every read and update is atomic. An agent whose stall input is high issues no table request. Agents advance independently of one another, and the final offsets do not depend on the order in which chunks post or on the stall pattern.

Top module: `scan_prefix_combiner`

## Requirements
- R1: After reset every table coverage count is 0, `done` is all zero and every offset reads 0. No `done` pulse appears until a total has been posted.
- R2: When agent j is granted after latching a total, it writes coverage 1 and its own total into entry j. For chunk 1 that write completes it: `done[0]` pulses with offset 0.
- R3: Each granted jump step of agent j reads entry t = j - coverage_j. It adds the coverage of t to coverage_j and the sum of t to sum_j. A stored coverage c at entry i means the sum covers chunks i-c+1 through i, so coverage only grows and never exceeds i.
- R4: While the target entry has coverage 0, the agent re-reads it on later grants and changes neither its coverage nor its sum.
- R5: Agent j finishes when its coverage equals j. In the cycle after that update, `done[j-1]` pulses for one cycle and `offset` slice j-1 holds the sum of the totals of chunks 1 through j-1, modulo 2^DATA_W.
- R6: With totals 7,15,9,20,5,14,11,8 for chunks 1..8, the offsets are 0,7,22,31,51,56,70,81, even when chunk 6 is held back for many cycles.
- R7: An agent with its `stall` bit high makes no table request. Later chunks that depend on it wait, and complete with correct offsets once it is released.
- R8: At most one agent is granted per cycle, only a requesting one, and the grant rotates round-robin.
- R9: Chunks may post in any order and at any time. Each agent finishes as soon as the entries it needs are ready.
- R10: Each agent pulses `done` exactly once per reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_valid | input | N_CHUNK | Bit j-1 pulses to hand chunk j's total to its agent |
| post_total | input | N_CHUNK*DATA_W | Chunk j's total in bits [DATA_W*(j-1) +: DATA_W] |
| stall | input | N_CHUNK | Bit j-1 high keeps agent j from requesting the table |
| done | output | N_CHUNK | One-cycle completion pulse per agent |
| offset | output | N_CHUNK*DATA_W | Sum of earlier chunks for chunk j in bits [DATA_W*(j-1) +: DATA_W], valid from the done pulse |

## Verification
The embedded assertions check several properties on every cycle. They check the one-hot, request-backed grant and the absence of requests while stalled. They check that a write only ever raises an entry's coverage and never beyond its index, and that nothing is folded while a target is still empty. They also check the single-cycle, full-coverage done pulse. Whether the offsets are arithmetically right under different post orders, stalls and wrap-around only shows in the bench scenarios. The same holds for dependent chunks waiting on a missing predecessor and then resuming, and for each agent finishing exactly once. The bench compares those results against a serial running sum.

// File: rtl/pfx_pkg.sv
// Shared types for the cross-chunk prefix combiner.
// Assumes: nothing beyond the standard language.
package pfx_pkg;
    typedef enum logic [1:0] {
        AG_IDLE = 2'd0,   // waiting for the chunk total
        AG_POST = 2'd1,   // total latched, publishing coverage 1
        AG_JUMP = 2'd2,   // folding predecessors in
        AG_DONE = 2'd3    // full prefix known
    } agent_state_t;
endpackage

// File: rtl/pfx_rr_arbiter.sv
// Round-robin arbiter: grants at most one requester per cycle, starting
// the search just after the last winner.
// Assumes: requests are level signals held until granted.
module pfx_rr_arbiter #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr_q;
    logic [IW-1:0] win;

    // Pick the first requester at or after the pointer.
    always_comb begin
        grant = '0;
        win   = ptr_q;
        for (int k = 0; k < N; k++) begin
            if (grant == '0 && req[(int'(ptr_q) + k) % N]) begin
                grant[(int'(ptr_q) + k) % N] = 1'b1;
                win = IW'((int'(ptr_q) + k) % N);
            end
        end
    end

    // Move the search start past the winner.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (|grant)
            ptr_q <= (win == IW'(N - 1)) ? '0 : win + IW'(1);
    end

    assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_grant_backed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);
    assert_grant_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|grant));
endmodule

// File: rtl/pfx_pair_table.sv
// Shared table of (coverage, sum) pairs, one per chunk, indexed from 1.
// One combinational read port and one write port. Read and write in the
// same cycle form an atomic read-modify-write for the granted agent.
// Assumes: only the arbiter's winner drives the write port.
module pfx_pair_table #(
    parameter int N  = 8,
    parameter int FW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [FW-1:0] waddr,
    input  logic [FW-1:0] wflag,
    input  logic [DW-1:0] wdata,
    input  logic [FW-1:0] raddr,
    output logic [FW-1:0] rflag,
    output logic [DW-1:0] rdata
);
    logic [FW-1:0] flag_q [N];
    logic [DW-1:0] data_q [N];
    logic [FW-1:0] cur_wflag;

    // Read the addressed pair and the entry about to be written.
    always_comb begin
        rflag     = '0;
        rdata     = '0;
        cur_wflag = '0;
        for (int i = 0; i < N; i++) begin
            if (FW'(i + 1) == raddr) begin
                rflag = flag_q[i];
                rdata = data_q[i];
            end
            if (FW'(i + 1) == waddr)
                cur_wflag = flag_q[i];
        end
    end

    // Store both fields of the written pair together.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                flag_q[i] <= '0;
                data_q[i] <= '0;
            end else if (we && FW'(i + 1) == waddr) begin
                flag_q[i] <= wflag;
                data_q[i] <= wdata;
            end
        end
    end

    assert_cover_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (wflag > cur_wflag));
    assert_cover_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (wflag <= waddr));
endmodule

// File: rtl/pfx_chunk_agent.sv
// Per-chunk agent: latches its chunk total, publishes coverage 1, then
// jumps back by its own coverage, folding in each predecessor pair until
// its coverage reaches its own index. Reports the offset once.
// Assumes: table reads are combinational and valid while granted.
module pfx_chunk_agent
    import pfx_pkg::*;
#(
    parameter int N   = 8,
    parameter int FW  = 4,
    parameter int DW  = 16,
    parameter int IDX = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          post_valid,
    input  logic [DW-1:0] post_total,
    input  logic          stall,
    input  logic          grant,
    input  logic [FW-1:0] rd_flag,
    input  logic [DW-1:0] rd_data,
    output logic          req,
    output logic [FW-1:0] tgt,
    output logic          we,
    output logic [FW-1:0] wr_flag,
    output logic [DW-1:0] wr_data,
    output logic          done,
    output logic [DW-1:0] offset
);
    localparam logic [FW-1:0] MY_ID = FW'(IDX);

    agent_state_t  state_q;
    logic [DW-1:0] total_q;
    logic [FW-1:0] own_flag;
    logic [DW-1:0] own_data;
    logic          done_q;
    logic [DW-1:0] offset_q;
    logic [FW-1:0] nflag;
    logic [DW-1:0] ndata;
    logic          fold;

    // Request, target and candidate write for this cycle.
    always_comb begin
        req     = (state_q == AG_POST || state_q == AG_JUMP) && !stall;
        tgt     = MY_ID - own_flag;
        nflag   = own_flag + rd_flag;
        ndata   = own_data + rd_data;
        fold    = grant && state_q == AG_JUMP && rd_flag != '0;
        we      = (grant && state_q == AG_POST) || fold;
        wr_flag = (state_q == AG_POST) ? FW'(1) : nflag;
        wr_data = (state_q == AG_POST) ? total_q : ndata;
    end

    // Agent sequencing and the local copy of its own pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= AG_IDLE;
            total_q  <= '0;
            own_flag <= '0;
            own_data <= '0;
            done_q   <= 1'b0;
            offset_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                AG_IDLE: if (post_valid) begin
                    total_q <= post_total;
                    state_q <= AG_POST;
                end
                AG_POST: if (grant) begin
                    own_flag <= FW'(1);
                    own_data <= total_q;
                    if (MY_ID == FW'(1)) begin
                        done_q   <= 1'b1;
                        offset_q <= '0;
                        state_q  <= AG_DONE;
                    end else begin
                        state_q  <= AG_JUMP;
                    end
                end
                AG_JUMP: if (fold) begin
                    own_flag <= nflag;
                    own_data <= ndata;
                    if (nflag == MY_ID) begin
                        done_q   <= 1'b1;
                        offset_q <= ndata - total_q;
                        state_q  <= AG_DONE;
                    end
                end
                default: state_q <= AG_DONE;
            endcase
        end
    end

    assign done   = done_q;
    assign offset = offset_q;

    assert_stall_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !req);
    assert_post_unit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && state_q == AG_POST) |=> (own_flag == FW'(1) && own_data == $past(total_q)));
    assert_wait_no_fold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && state_q == AG_JUMP && rd_flag == '0) |=> ($stable(own_flag) && $stable(own_data)));
    assert_done_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (own_flag == MY_ID));
    assert_done_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && state_q == AG_DONE));
endmodule

// File: rtl/scan_prefix_combiner.sv
// Top: N_CHUNK agents share one pair table through a round-robin arbiter.
// The winner's target read and own-entry write happen in one cycle.
// Assumes: totals for chunk j arrive on slice j-1 with a post_valid pulse.
module scan_prefix_combiner #(
    parameter int N_CHUNK = 8,
    parameter int DATA_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_CHUNK-1:0]        post_valid,
    input  logic [N_CHUNK*DATA_W-1:0] post_total,
    input  logic [N_CHUNK-1:0]        stall,
    output logic [N_CHUNK-1:0]        done,
    output logic [N_CHUNK*DATA_W-1:0] offset
);
    localparam int FW = $clog2(N_CHUNK + 1);

    logic [N_CHUNK-1:0] req;
    logic [N_CHUNK-1:0] grant;
    logic [N_CHUNK-1:0] we_a;
    logic [FW-1:0]      tgt_a   [N_CHUNK];
    logic [FW-1:0]      wflag_a [N_CHUNK];
    logic [DATA_W-1:0]  wdata_a [N_CHUNK];

    logic          t_we;
    logic [FW-1:0] t_waddr;
    logic [FW-1:0] t_wflag;
    logic [DATA_W-1:0] t_wdata;
    logic [FW-1:0] t_raddr;
    logic [FW-1:0] rd_flag;
    logic [DATA_W-1:0] rd_data;

    pfx_rr_arbiter #(.N(N_CHUNK)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req), .grant(grant)
    );

    // Route the granted agent onto the table ports.
    always_comb begin
        t_we    = 1'b0;
        t_waddr = FW'(1);
        t_wflag = '0;
        t_wdata = '0;
        t_raddr = FW'(1);
        for (int g = 0; g < N_CHUNK; g++) begin
            if (grant[g]) begin
                t_we    = we_a[g];
                t_waddr = FW'(g + 1);
                t_wflag = wflag_a[g];
                t_wdata = wdata_a[g];
                t_raddr = tgt_a[g];
            end
        end
    end

    pfx_pair_table #(.N(N_CHUNK), .FW(FW), .DW(DATA_W)) u_tab (
        .clk(clk), .rst_n(rst_n),
        .we(t_we), .waddr(t_waddr), .wflag(t_wflag), .wdata(t_wdata),
        .raddr(t_raddr), .rflag(rd_flag), .rdata(rd_data)
    );

    for (genvar g = 0; g < N_CHUNK; g++) begin : g_agent
        pfx_chunk_agent #(.N(N_CHUNK), .FW(FW), .DW(DATA_W), .IDX(g + 1)) u_agent (
            .clk(clk), .rst_n(rst_n),
            .post_valid(post_valid[g]),
            .post_total(post_total[g*DATA_W +: DATA_W]),
            .stall(stall[g]),
            .grant(grant[g]),
            .rd_flag(rd_flag), .rd_data(rd_data),
            .req(req[g]), .tgt(tgt_a[g]),
            .we(we_a[g]), .wr_flag(wflag_a[g]), .wr_data(wdata_a[g]),
            .done(done[g]),
            .offset(offset[g*DATA_W +: DATA_W])
        );
    end
endmodule

// File: tb/scan_prefix_combiner_test.sv
module scan_prefix_combiner_test;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int DW = 16;
    localparam int NSC = 4;

    // Scenario vectors: chunk j at slice j-1.
    localparam logic [N*DW-1:0] SC_TOT [NSC] = '{
        {16'd8, 16'd11, 16'd14, 16'd5, 16'd20, 16'd9, 16'd15, 16'd7},
        {16'd100, 16'd3, 16'd0, 16'd42, 16'd1, 16'd77, 16'd9, 16'd250},
        {16'hF000, 16'h8001, 16'hFFFF, 16'h1234, 16'hC000, 16'h7FFF, 16'h0101, 16'hEEEE},
        {16'd1, 16'd0, 16'd1, 16'd0, 16'd1, 16'd0, 16'd1, 16'd0}
    };
    localparam logic [N*4-1:0] SC_DLY [NSC] = '{
        {4'd2, 4'd0, 4'd5, 4'd1, 4'd3, 4'd0, 4'd4, 4'd6},
        {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7},
        {4'd9, 4'd3, 4'd12, 4'd0, 4'd7, 4'd15, 4'd1, 4'd4},
        {4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0}
    };
    localparam logic [N-1:0]  SC_MASK [NSC] = '{8'b0010_0000, 8'b1000_0001, 8'b1111_1111, 8'b0000_0000};
    localparam logic [15:0]   SC_SEED [NSC] = '{16'hACE1, 16'h1D2B, 16'h7F31, 16'h0001};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] post_valid = '0;
    logic [N*DW-1:0] post_total = '0;
    logic [N-1:0] stall = '0;
    logic [N-1:0] done;
    logic [N*DW-1:0] offset;

    int checks = 0;
    int errors = 0;
    int seen_cnt [N];
    logic [DW-1:0] seen_off [N];

    scan_prefix_combiner #(.N_CHUNK(N), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_total(post_total),
        .stall(stall), .done(done), .offset(offset)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Record done pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n)
            for (int i = 0; i < N; i++)
                if (done[i]) begin
                    seen_cnt[i] = seen_cnt[i] + 1;
                    seen_off[i] = offset[i*DW +: DW];
                end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; post_valid = '0; stall = '0;
        repeat (3) @(posedge clk);
        #1;
        for (int i = 0; i < N; i++) begin seen_cnt[i] = 0; seen_off[i] = '0; end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic post_one(input int ch, input logic [DW-1:0] val);
        @(negedge clk);
        post_total[(ch-1)*DW +: DW] = val;
        post_valid = '0;
        post_valid[ch-1] = 1'b1;
        @(negedge clk);
        post_valid = '0;
    endtask

    // Serial reference and comparison against every chunk.
    task automatic check_all(input logic [N*DW-1:0] tot, input string tag);
        logic [DW-1:0] run;
        run = '0;
        for (int i = 0; i < N; i++) begin
            chk($sformatf("%s R10 chunk %0d done count", tag, i + 1), seen_cnt[i], 1);
            chk($sformatf("%s R5 chunk %0d offset", tag, i + 1), seen_off[i], run);
            run = run + tot[i*DW +: DW];
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R5 actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Table-driven scenarios: R6 (example, chunk 6 held), R9 orders, wrap.
        for (int s = 0; s < NSC; s++) begin
            logic [15:0] lfsr;
            apply_reset();
            post_total = SC_TOT[s];
            lfsr = SC_SEED[s];
            for (int cyc = 0; cyc < 400; cyc++) begin
                @(negedge clk);
                for (int i = 0; i < N; i++) begin
                    post_valid[i] = (cyc == int'(SC_DLY[s][i*4 +: 4]));
                    stall[i] = (cyc < 150) && SC_MASK[s][i] && ((cyc < 40) || lfsr[i]);
                end
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            end
            post_valid = '0; stall = '0;
            check_all(SC_TOT[s], (s == 0) ? "R6 R7 R8 R9" : "R9 R8");
        end

        // R1: reset state, nothing posted.
        apply_reset();
        #1;
        chk("R1 done after reset", done, 0);
        chk("R1 offset after reset", offset[31:0], 0);
        repeat (10) @(negedge clk);
        chk("R1 no done without post", seen_cnt[0] + seen_cnt[7], 0);

        // R4: chunk 2 waits on an empty chunk 1, then completes.
        post_one(2, 16'd9);
        repeat (40) @(negedge clk);
        chk("R4 chunk 2 waits on empty target", seen_cnt[1], 0);
        post_one(1, 16'd5);
        repeat (20) @(negedge clk);
        chk("R2 chunk 1 done on post", seen_cnt[0], 1);
        chk("R2 chunk 1 offset zero", seen_off[0], 0);
        chk("R4 chunk 2 done after wait", seen_cnt[1], 1);
        chk("R3 chunk 2 offset folded", seen_off[1], 5);

        // R7: chunk 5 stalled blocks chunks 5..8 until released.
        apply_reset();
        stall[4] = 1'b1;
        post_total = {16'd6, 16'd2, 16'd9, 16'd5, 16'd1, 16'd4, 16'd1, 16'd3};
        @(negedge clk);
        post_valid = '1;
        @(negedge clk);
        post_valid = '0;
        repeat (60) @(negedge clk);
        chk("R7 chunk 4 done while 5 stalled", seen_cnt[3], 1);
        chk("R7 chunk 4 offset", seen_off[3], 8);
        chk("R7 chunk 5 held by stall", seen_cnt[4], 0);
        chk("R7 chunk 8 waits on stalled chunk", seen_cnt[7], 0);
        stall = '0;
        repeat (60) @(negedge clk);
        chk("R7 chunk 5 offset after release", seen_off[4], 9);
        chk("R7 chunk 8 offset after release", seen_off[7], 25);
        chk("R10 chunk 8 single done", seen_cnt[7], 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule